// File: doc/BRIEF.md
# Serial Flash Pin Front End

This block sits directly behind the pins of a serial NOR flash slave. It watches chip select, the serial clock and four data lines, and turns them into a stream of received bytes and a stream of transmitted bits. Command, address and write data are captured on rising clock edges. Read data is launched on falling edges. Each edge carries one, two or four bits, depending on the lane mode chosen by the command decoder behind it.

The block also decides when each data pin may be driven. It implements the pause function on the hold pin, and it gates status-register writes with the write-protect pin and a protect bit. When the quad-enable bit is set, data line 2 and data line 3 stop acting as write-protect and hold and carry data only. A busy input keeps the block's activity flag raised after deselect until an internal write cycle ends.

All pins are sampled on a fast system clock `clk`. Serial clock edges are found by comparing each sample with the previous one, and every registered output changes one `clk` cycle after the sample that caused it. The serial clock idles low.

Top module: `sflash_pin_front`

## Requirements
- R1: While `cs_n` is high, `io_oe` is 4'b0000.
- R2: After reset, the block does nothing until it has sampled `cs_n` high at least once. A select that is already low coming out of reset produces no bit count, no received byte and no output enable.
- R3: While selected with `out_phase` = 0, each rising serial clock edge shifts bits into the receive register, most significant bit first. When the eighth bit arrives, `rx_data` holds the byte and `rx_valid` pulses for one cycle. Every accepted rising edge, in either phase, adds the bits per edge to `bit_cnt`.
- R4: In single mode (`lane_mode` = 2'd0), input is taken from io_in[0] and output is placed on io_out[1]. With `out_phase` = 1, `io_oe` = 4'b0010. Each falling edge drives the next bit of the byte, most significant bit first. The falling edge that starts a new byte takes it from `tx_data` and pulses `tx_next` for one cycle.
- R5: In dual mode (`lane_mode` = 2'd1), each edge moves two bits on io[1:0], with io[1] carrying the higher bit. With `out_phase` = 1, `io_oe` = 4'b0011.
- R6: In quad mode (`lane_mode` = 2'd2), each edge moves four bits on io[3:0], with io[3] carrying the highest bit, and `io_oe` = 4'b1111 in the output phase. Quad mode works only when `qe` = 1. With `qe` = 0 in quad mode, edges are not counted, nothing is captured and `io_oe` stays 0. `lane_mode` 2'd3 behaves the same way.
- R7: With `qe` = 0, io_in[3] acts as an active-low hold. Holding it low while selected forces `io_oe` to 0 and discards serial clock edges. When hold is released, shifting continues from the bit where it stopped.
- R8: With `qe` = 1, io_in[3] low does not pause the block.
- R9: `sr_wr_ok` equals `sr_wr_req`, except that it is 0 when `srp` = 1, io_in[2] (active-low write protect) = 0 and `qe` = 0.
- R10: `cs_n` high clears `bit_cnt` and the partial receive and transmit state. A byte cut short by deselect never produces `rx_valid`.
- R11: `active` is set the cycle after a selected sample. After deselect it stays 1 while `busy` = 1, and it drops the cycle after a sample with `cs_n` = 1 and `busy` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock pin level |
| io_in | input | 4 | Data pin levels; [2] doubles as write protect, [3] as hold when `qe` = 0 |
| io_out | output | 4 | Data pin drive values |
| io_oe | output | 4 | Per-pin output enable |
| qe | input | 1 | Quad-enable bit |
| srp | input | 1 | Status-register protect bit |
| lane_mode | input | 2 | 0 single, 1 dual, 2 quad, 3 invalid |
| out_phase | input | 1 | Decoder marks the data-out phase |
| tx_data | input | 8 | Next byte to transmit |
| tx_next | output | 1 | Pulse: `tx_data` was taken |
| rx_data | output | 8 | Last complete received byte |
| rx_valid | output | 1 | Pulse: `rx_data` updated |
| bit_cnt | output | CNT_W | Bits clocked since select |
| sr_wr_req | input | 1 | Decoder requests a status-register write |
| sr_wr_ok | output | 1 | Status-register write permitted |
| busy | input | 1 | Internal write cycle in progress |
| active | output | 1 | Active (not standby) indication |

## Verification
The assertions check, on every cycle, that the pins float while deselected and in quad mode without quad enable, that a hold freezes the bit counter, that a deselect clears the counter and the byte strobe, that no byte is reported before arming, that the protect gate blocks writes, and that activity drops once busy ends after deselect. What they cannot show is the data itself. Bit order per lane width, byte assembly across a hold, the serial output stream, and recovery of a clean byte after an aborted transfer are shown only by the bench scenarios, which a behavioural queue-based model checks on every clock.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

    localparam int BYTE_W = 8;
    localparam int LANES  = 4;

    typedef enum logic [1:0] {
        LANE_X1   = 2'd0,
        LANE_X2   = 2'd1,
        LANE_X4   = 2'd2,
        LANE_RSVD = 2'd3
    } lane_e;

    // Per-cycle pin events shared between the control and shift units.
    typedef struct packed {
        logic sel;   // armed and chip select low
        logic hold;  // paused by hold pin
        logic go;    // edges may be acted on
        logic rise;  // accepted rising serial clock edge
        logic fall;  // accepted falling serial clock edge
    } pin_ev_t;

    // Bits moved per edge; zero means the mode is not usable.
    function automatic logic [2:0] lane_step(lane_e m, logic quad_en);
        case (m)
            LANE_X1: return 3'd1;
            LANE_X2: return 3'd2;
            LANE_X4: return quad_en ? 3'd4 : 3'd0;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [LANES-1:0] lane_oe_mask(lane_e m);
        case (m)
            LANE_X1: return 4'b0010;
            LANE_X2: return 4'b0011;
            LANE_X4: return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

    // Append the sampled lanes below the existing bits.
    function automatic logic [BYTE_W-1:0] lane_shift_in(logic [BYTE_W-1:0] sh,
                                                       logic [LANES-1:0] pins,
                                                       lane_e m);
        case (m)
            LANE_X2: return {sh[BYTE_W-3:0], pins[1:0]};
            LANE_X4: return {sh[BYTE_W-5:0], pins[3:0]};
            default: return {sh[BYTE_W-2:0], pins[0]};
        endcase
    endfunction

    // Place the top bits of a byte onto the pins used by the mode.
    function automatic logic [LANES-1:0] lane_place_out(logic [BYTE_W-1:0] src, lane_e m);
        case (m)
            LANE_X2: return {2'b00, src[BYTE_W-1 -: 2]};
            LANE_X4: return src[BYTE_W-1 -: 4];
            default: return {2'b00, src[BYTE_W-1], 1'b0};
        endcase
    endfunction

endpackage

// File: rtl/sfp_pin_ctrl.sv
module sfp_pin_ctrl
    import sfp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic [LANES-1:0] io_in,
    input  logic             qe,
    input  logic             srp,
    input  lane_e            lane,
    input  logic             out_phase,
    input  logic             sr_wr_req,
    input  logic             busy,
    output pin_ev_t          ev,
    output logic [2:0]       step,
    output logic             armed,
    output logic             active,
    output logic [LANES-1:0] io_oe,
    output logic             sr_wr_ok
);

    logic sclk_q;
    logic armed_q;
    logic active_q;
    logic wp_block;

    always_comb begin
        step    = lane_step(lane, qe);
        ev.sel  = armed_q & ~cs_n;
        ev.hold = ev.sel & ~qe & ~io_in[3];
        ev.go   = ev.sel & ~ev.hold & (step != 3'd0);
        ev.rise = ev.go & sclk & ~sclk_q;
        ev.fall = ev.go & ~sclk & sclk_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q   <= 1'b0;
            armed_q  <= 1'b0;
            active_q <= 1'b0;
        end else begin
            sclk_q   <= sclk;
            armed_q  <= armed_q | cs_n;
            active_q <= ev.sel | (active_q & busy);
        end
    end

    assign wp_block = srp & ~qe & ~io_in[2];
    assign sr_wr_ok = sr_wr_req & ~wp_block;
    assign io_oe    = (ev.go & out_phase) ? lane_oe_mask(lane) : '0;
    assign armed    = armed_q;
    assign active   = active_q;

    // R11: standby follows once deselected and idle
    a_r11_standby: assert property (@(posedge clk) disable iff (rst)
        (cs_n && !busy) |=> !active);

    // R9: protected status register cannot be written
    a_r9_wp_gate: assert property (@(posedge clk) disable iff (rst)
        (srp && !qe && !io_in[2]) |-> !sr_wr_ok);

endmodule

// File: rtl/sfp_rx_shift.sv
module sfp_rx_shift
    import sfp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              rise,
    input  logic              capture,
    input  lane_e             lane,
    input  logic [2:0]        step,
    input  logic [LANES-1:0]  pins,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic [CNT_W-1:0]  bit_cnt
);

    localparam int FILL_W = $clog2(BYTE_W + 1);

    logic [BYTE_W-1:0] sh_q;
    logic [FILL_W-1:0] fill_q;
    logic [BYTE_W-1:0] sh_nxt;
    logic [FILL_W-1:0] fill_nxt;

    assign sh_nxt   = lane_shift_in(sh_q, pins, lane);
    assign fill_nxt = fill_q + FILL_W'(step);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh_q     <= '0;
            fill_q   <= '0;
            bit_cnt  <= '0;
            rx_valid <= 1'b0;
            if (rst) rx_data <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (rise) begin
                bit_cnt <= bit_cnt + CNT_W'(step);
                if (capture) begin
                    if (fill_nxt == FILL_W'(BYTE_W)) begin
                        rx_data  <= sh_nxt;
                        rx_valid <= 1'b1;
                        fill_q   <= '0;
                        sh_q     <= '0;
                    end else begin
                        fill_q <= fill_nxt;
                        sh_q   <= sh_nxt;
                    end
                end
            end
        end
    end

    // R10: deselect wipes the count and any byte strobe
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (bit_cnt == '0) && !rx_valid);

endmodule

// File: rtl/sfp_tx_shift.sv
module sfp_tx_shift
    import sfp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              fall,
    input  lane_e             lane,
    input  logic [2:0]        step,
    input  logic [BYTE_W-1:0] tx_data,
    output logic [LANES-1:0]  out_bits,
    output logic              tx_next
);

    localparam int LEFT_W = $clog2(BYTE_W + 1);

    logic [BYTE_W-1:0] sh_q;
    logic [LEFT_W-1:0] left_q;
    logic              empty;
    logic [BYTE_W-1:0] src;
    logic [LEFT_W-1:0] avail;

    assign empty = (left_q == '0);
    assign src   = empty ? tx_data : sh_q;
    assign avail = empty ? LEFT_W'(BYTE_W) : left_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh_q     <= '0;
            left_q   <= '0;
            out_bits <= '0;
            tx_next  <= 1'b0;
        end else begin
            tx_next <= 1'b0;
            if (fall) begin
                out_bits <= lane_place_out(src, lane);
                sh_q     <= src << step;
                left_q   <= avail - LEFT_W'(step);
                tx_next  <= empty;
            end
        end
    end

endmodule

// File: rtl/sflash_pin_front.sv
module sflash_pin_front
    import sfp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [3:0]        io_in,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    input  logic              qe,
    input  logic              srp,
    input  logic [1:0]        lane_mode,
    input  logic              out_phase,
    input  logic [7:0]        tx_data,
    output logic              tx_next,
    output logic [7:0]        rx_data,
    output logic              rx_valid,
    output logic [CNT_W-1:0]  bit_cnt,
    input  logic              sr_wr_req,
    output logic              sr_wr_ok,
    input  logic              busy,
    output logic              active
);

    lane_e      lane;
    pin_ev_t    ev;
    logic [2:0] step;
    logic       armed;

    assign lane = lane_e'(lane_mode);

    sfp_pin_ctrl u_ctrl (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .io_in(io_in),
        .qe(qe), .srp(srp), .lane(lane), .out_phase(out_phase),
        .sr_wr_req(sr_wr_req), .busy(busy), .ev(ev), .step(step),
        .armed(armed), .active(active), .io_oe(io_oe), .sr_wr_ok(sr_wr_ok)
    );

    sfp_rx_shift #(.CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst(rst), .clr(cs_n), .rise(ev.rise),
        .capture(~out_phase), .lane(lane), .step(step), .pins(io_in),
        .rx_data(rx_data), .rx_valid(rx_valid), .bit_cnt(bit_cnt)
    );

    sfp_tx_shift u_tx (
        .clk(clk), .rst(rst), .clr(cs_n), .fall(ev.fall & out_phase),
        .lane(lane), .step(step), .tx_data(tx_data),
        .out_bits(io_out), .tx_next(tx_next)
    );

    // R1: deselected pins float
    a_r1_float: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (io_oe == 4'b0000));

    // R2: no byte before the first deselect has armed the block
    a_r2_armed: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> armed);

    // R6: quad lanes never drive without quad enable
    a_r6_quad_gate: assert property (@(posedge clk) disable iff (rst)
        (lane_mode == 2'd2 && !qe) |-> (io_oe == 4'b0000));

    // R7: a hold freezes the bit counter
    a_r7_hold_freeze: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && armed && !qe && !io_in[3]) |=> $stable(bit_cnt));

endmodule

// File: tb/sflash_pin_front_tb_top.sv
module sflash_pin_front_tb_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cs_n, sclk, qe, srp, out_phase, sr_wr_req, busy;
    logic [3:0]  io_in;
    logic [1:0]  lane_mode;
    logic [7:0]  tx_data;
    logic [3:0]  io_out, io_oe;
    logic        tx_next, rx_valid, sr_wr_ok, active;
    logic [7:0]  rx_data;
    logic [15:0] bit_cnt;

    int checks = 0;
    int failures = 0;
    int rxv_seen = 0;
    int txn_seen = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    sflash_pin_front dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .io_in(io_in),
        .io_out(io_out), .io_oe(io_oe), .qe(qe), .srp(srp),
        .lane_mode(lane_mode), .out_phase(out_phase), .tx_data(tx_data),
        .tx_next(tx_next), .rx_data(rx_data), .rx_valid(rx_valid),
        .bit_cnt(bit_cnt), .sr_wr_req(sr_wr_req), .sr_wr_ok(sr_wr_ok),
        .busy(busy), .active(active)
    );

    // ---------------- behavioural reference model ----------------
    bit        m_armed, m_prev, m_active, m_rxv, m_txn;
    bit [15:0] m_bits;
    bit [7:0]  m_rxd;
    bit [3:0]  m_out;
    bit        rxq[$];
    bit        txq[$];

    function automatic int m_step();
        if (lane_mode == 2'd0) return 1;
        if (lane_mode == 2'd1) return 2;
        if (lane_mode == 2'd2 && qe) return 4;
        return 0;
    endfunction

    always @(posedge clk) begin
        bit sel, hold, go;
        int st;
        m_rxv = 0;
        m_txn = 0;
        if (rst) begin
            m_armed = 0; m_prev = 0; m_active = 0; m_bits = 0;
            m_rxd = 0; m_out = 0; rxq.delete(); txq.delete();
        end else begin
            sel  = m_armed && !cs_n;
            hold = sel && !qe && !io_in[3];
            st   = m_step();
            go   = sel && !hold && st != 0;
            if (cs_n) begin
                m_bits = 0; m_out = 0; rxq.delete(); txq.delete();
            end else if (go) begin
                if (sclk && !m_prev) begin
                    m_bits += 16'(st);
                    if (!out_phase) begin
                        for (int k = st - 1; k >= 0; k--) rxq.push_back(io_in[k]);
                        if (rxq.size() == 8) begin
                            m_rxd = 0;
                            for (int k = 0; k < 8; k++) m_rxd = {m_rxd[6:0], rxq[k]};
                            m_rxv = 1;
                            rxq.delete();
                        end
                    end
                end
                if (!sclk && m_prev && out_phase) begin
                    if (txq.size() == 0) begin
                        for (int k = 7; k >= 0; k--) txq.push_back(tx_data[k]);
                        m_txn = 1;
                    end
                    m_out = 0;
                    for (int k = st - 1; k >= 0; k--) m_out[k] = txq.pop_front();
                    if (st == 1) m_out = {2'b00, m_out[0], 1'b0};
                end
            end
            m_active = sel || (m_active && busy);
            m_prev   = sclk;
            m_armed  = m_armed || cs_n;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one system-clock step: compare with the model, then the caller drives
    task automatic tick();
        bit sel, hold;
        bit [3:0] e_oe;
        @(negedge clk);
        sel  = m_armed && !cs_n;
        hold = sel && !qe && !io_in[3];
        e_oe = 4'b0000;
        if (sel && !hold && m_step() != 0 && out_phase)
            e_oe = (m_step() == 1) ? 4'b0010 : (m_step() == 2) ? 4'b0011 : 4'b1111;
        chk("model io_oe (R1 R4 R5 R6 R7)", int'(io_oe), int'(e_oe));
        chk("model io_out (R4 R5 R6)", int'(io_out), int'(m_out));
        chk("model bit_cnt (R2 R3 R7 R10)", int'(bit_cnt), int'(m_bits));
        chk("model rx_valid (R3 R10)", int'(rx_valid), int'(m_rxv));
        chk("model rx_data (R3)", int'(rx_data), int'(m_rxd));
        chk("model tx_next (R4)", int'(tx_next), int'(m_txn));
        chk("model active (R11)", int'(active), int'(m_active));
        chk("model sr_wr_ok (R9)", int'(sr_wr_ok),
            int'(sr_wr_req && !(srp && !qe && !io_in[2])));
        if (rx_valid) rxv_seen++;
        if (tx_next)  txn_seen++;
    endtask

    task automatic edge_pair();
        sclk = 1'b1; tick(); tick();
        sclk = 1'b0; tick(); tick();
    endtask

    task automatic shift_bits(input bit [7:0] b, input int st, input int n);
        bit [7:0] v = b;
        for (int i = 0; i < n; i++) begin
            if (st == 1)      io_in[0]   = v[7];
            else if (st == 2) io_in[1:0] = v[7:6];
            else              io_in      = v[7:4];
            v = v << st;
            edge_pair();
        end
    endtask

    task automatic recv(input int st, output bit [7:0] b);
        b = 0;
        for (int i = 0; i < 8 / st; i++) begin
            edge_pair();
            if (st == 1)      b = {b[6:0], io_out[1]};
            else if (st == 2) b = {b[5:0], io_out[1:0]};
            else              b = {b[3:0], io_out};
        end
    endtask

    task automatic sel_on();  cs_n = 1'b0; tick(); tick(); endtask
    task automatic sel_off(); cs_n = 1'b1; tick(); tick(); endtask

    initial begin
        bit [7:0] got;
        int rx0;
        rst = 1'b1; cs_n = 1'b0; sclk = 1'b0; io_in = 4'b1100; qe = 1'b0;
        srp = 1'b0; lane_mode = 2'd0; out_phase = 1'b1; tx_data = 8'h00;
        sr_wr_req = 1'b0; busy = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk("R2 reset io_oe with select already low", int'(io_oe), 0);
        chk("R11 reset active", int'(active), 0);
        out_phase = 1'b0;
        shift_bits(8'hFF, 1, 8);
        chk("R2 unarmed bit_cnt", int'(bit_cnt), 0);
        chk("R2 unarmed no byte", rxv_seen, 0);
        out_phase = 1'b1;
        sel_off();
        chk("R1 deselected float", int'(io_oe), 0);
        out_phase = 1'b0;

        // R3 single write
        sel_on();
        shift_bits(8'hA5, 1, 8);
        chk("R3 rx_data single", int'(rx_data), 8'hA5);
        chk("R3 bit_cnt single", int'(bit_cnt), 8);
        chk("R3 one byte strobe", rxv_seen, 1);
        sel_off();

        // R4 single read
        out_phase = 1'b1; tx_data = 8'h3C;
        sel_on();
        chk("R4 single oe", int'(io_oe), 4'b0010);
        recv(1, got);
        chk("R4 single read byte", int'(got), 8'h3C);
        chk("R4 tx_next once", txn_seen, 1);
        sel_off();
        out_phase = 1'b0;

        // R5 dual
        lane_mode = 2'd1;
        sel_on();
        shift_bits(8'h96, 2, 4);
        chk("R5 dual rx_data", int'(rx_data), 8'h96);
        chk("R5 dual bit_cnt", int'(bit_cnt), 8);
        out_phase = 1'b1; tx_data = 8'hC9;
        tick();
        chk("R5 dual oe", int'(io_oe), 4'b0011);
        recv(2, got);
        chk("R5 dual read byte", int'(got), 8'hC9);
        sel_off();
        out_phase = 1'b0;

        // R6 quad, first without quad enable
        lane_mode = 2'd2;
        rx0 = rxv_seen;
        sel_on();
        shift_bits(8'h5A, 4, 2);
        chk("R6 quad without qe bit_cnt", int'(bit_cnt), 0);
        chk("R6 quad without qe no byte", rxv_seen, rx0);
        out_phase = 1'b1; tick();
        chk("R6 quad without qe oe", int'(io_oe), 0);
        sel_off();
        out_phase = 1'b0; qe = 1'b1;
        sel_on();
        shift_bits(8'h5A, 4, 2);
        chk("R6 quad rx_data", int'(rx_data), 8'h5A);
        out_phase = 1'b1; tx_data = 8'hE1; tick();
        chk("R6 quad oe", int'(io_oe), 4'b1111);
        recv(4, got);
        chk("R6 quad read byte", int'(got), 8'hE1);
        sel_off();
        qe = 1'b0; lane_mode = 2'd0; out_phase = 1'b0; io_in = 4'b1100;

        // R7 hold mid-byte
        sel_on();
        shift_bits(8'hB4, 1, 4);
        io_in[3] = 1'b0; tick();
        out_phase = 1'b1; tick();
        chk("R7 hold floats output", int'(io_oe), 0);
        out_phase = 1'b0;
        io_in[0] = 1'b1; edge_pair(); edge_pair();
        chk("R7 hold ignores clock", int'(bit_cnt), 4);
        io_in[3] = 1'b1; tick();
        shift_bits(8'h40, 1, 4);
        chk("R7 resumed byte", int'(rx_data), 8'hB4);
        sel_off();

        // R8 quad enable disables hold
        qe = 1'b1;
        sel_on();
        io_in[3] = 1'b0;
        shift_bits(8'hF0, 1, 8);
        chk("R8 no pause bit_cnt", int'(bit_cnt), 8);
        chk("R8 no pause rx_data", int'(rx_data), 8'hF0);
        sel_off();
        qe = 1'b0; io_in = 4'b1100;

        // R9 protect gate
        sr_wr_req = 1'b1; srp = 1'b1; io_in[2] = 1'b0; tick();
        chk("R9 blocked", int'(sr_wr_ok), 0);
        io_in[2] = 1'b1; tick();
        chk("R9 wp high allows", int'(sr_wr_ok), 1);
        srp = 1'b0; io_in[2] = 1'b0; tick();
        chk("R9 srp clear allows", int'(sr_wr_ok), 1);
        srp = 1'b1; qe = 1'b1; tick();
        chk("R9 qe overrides wp", int'(sr_wr_ok), 1);
        sr_wr_req = 1'b0; tick();
        chk("R9 no request", int'(sr_wr_ok), 0);
        qe = 1'b0; srp = 1'b0; io_in = 4'b1100;

        // R10 aborted byte
        sel_on();
        rx0 = rxv_seen;
        shift_bits(8'hFF, 1, 5);
        sel_off();
        chk("R10 cleared count", int'(bit_cnt), 0);
        chk("R10 no strobe", rxv_seen, rx0);
        sel_on();
        shift_bits(8'h69, 1, 8);
        chk("R10 clean next byte", int'(rx_data), 8'h69);

        // R11 busy keeps active
        busy = 1'b1; tick();
        sel_off(); tick();
        chk("R11 active while busy", int'(active), 1);
        busy = 1'b0; tick(); tick();
        chk("R11 standby after busy", int'(active), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule